// File: doc/BRIEF.md
# General-Purpose Bidirectional I/O Port

This block is an eight-pin general-purpose I/O port controlled over a small register bus. Software sets, for every pin, a direction bit and a drive/pull-up bit, and can read back a synchronized copy of the pad levels. Toward the pad ring the port produces, per pin, an output enable, a drive value and a pull-up enable, and it takes the raw pad input back in.

A pin whose direction bit is set drives its drive bit onto the pad. A pin whose direction bit is clear is an input. On an input pin a set drive bit turns on the pull-up, unless the chip-wide pull-up disable input is high. Pad levels reach the pin-sample address through a transparent latch followed by a flip-flop, both on the port clock. A sleep input forces the synchronizer's input low, so floating pads cannot toggle it. Reset clears both configuration registers asynchronously, so every pad is released even while the clock is stopped.

Register selects on `bus_addr`: 0 is the pin sample (read only), 1 is direction, 2 is drive/pull-up, and 3 is unused.

Top module: `gpio_port`

## Requirements
- R1: For each pin n, `pad_oe[n]` equals bit n of the direction register (1 means output, 0 means input).
- R2: `pad_out[n]` equals bit n of the drive register when the pin is an output, and is 0 when the pin is an input.
- R3: `pad_pu[n]` is 1 exactly when pin n is an input, its drive bit is 1 and `pullup_off` is low.
- R4: Driving `rst_n` low clears the direction and drive registers at once, without a clock edge, so all `pad_oe` and `pad_pu` bits are 0 and both registers read back 0.
- R5: With `bus_rd` high, address 1 returns the direction register and address 2 returns the drive register (the stored values, not the pads). Address 3 returns 0, and `bus_rdata` is 0 while `bus_rd` is low.
- R6: Address 0 returns the pad input after a latch that is transparent while `clk` is low and a flip-flop on the rising edge. A pad change made just after a rising edge is not visible before the next rising edge and is visible after it.
- R7: While `sleep` is high the synchronizer input is held low, so address 0 reads 0 after `sleep` has been high for two rising edges. The pad level returns once `sleep` is low again.
- R8: A write to address 0 or address 3 changes neither the direction register nor the drive register.
- R9: Each pin's `pad_oe`, `pad_out` and `pad_pu` depend only on that pin's own register bits and the global inputs, so pins in mixed configurations do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, used for register writes and the synchronizer |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from the select |
| pullup_off | input | 1 | Global pull-up disable |
| sleep | input | 1 | Forces the synchronizer input low |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The bench builds the port with its default width of eight pins, so one register value holds a mixed configuration of all four direction/drive pairings, each occurring twice across the port. Every vector then covers every per-pin case at once, with the global disable both low and high. The full byte width also lets distinct patterns on the pads expose a swapped or dropped bit in the synchronizer, and shows that sleep and the asynchronous reset release all pins together.

// File: rtl/gpio_port_pkg.sv
// Package: register selects and shared constants for the I/O port.
// Assumes a two-bit select; the sample, direction and drive selects are fixed.
package gpio_port_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_OUT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Module: direction and drive/pull-up storage for the whole port.
// Takes writes on the rising edge of clk. Assumes rst_n is asynchronous and
// active low; the sample and unused selects hold no storage.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  drv_q
);
    logic dir_hit;
    logic drv_hit;

    // Decode which register the current write targets.
    always_comb begin
        dir_hit = wr_en && (wr_sel == SEL_DIR);
        drv_hit = wr_en && (wr_sel == SEL_OUT);
    end

    // Direction register, cleared asynchronously by reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_hit) begin
            dir_q <= wr_data;
        end
    end

    // Drive/pull-up register, cleared asynchronously by reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else if (drv_hit) begin
            drv_q <= wr_data;
        end
    end
endmodule

// File: rtl/gpio_pin_drive.sv
// Module: pad control for one pin.
// Purely combinational. Assumes the direction and drive bits come from
// registers; the global pull-up disable overrides the pull-up only.
module gpio_pin_drive (
    input  logic dir_bit,
    input  logic drv_bit,
    input  logic pu_disable,
    output logic oe,
    output logic out_val,
    output logic pu_en
);
    // Derive the enable, the drive level and the pull-up from this pin's bits.
    always_comb begin
        oe      = dir_bit;
        out_val = dir_bit & drv_bit;
        pu_en   = ~dir_bit & drv_bit & ~pu_disable;
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Module: pad input synchronizer, a latch then a flip-flop.
// The latch passes data while clk is low and holds while clk is high; the
// flop samples on the rising edge. Assumes sleep may change at any time and
// forces the latch input low while high.
module gpio_in_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] sample
);
    logic [WIDTH-1:0] gated;
    logic [WIDTH-1:0] held;

    // Force the synchronizer input low during sleep.
    always_comb begin
        gated = sleep ? '0 : pad_in;
    end

    // First stage: transparent while the clock is low.
    always_latch begin
        if (!clk) begin
            held = gated;
        end
    end

    // Second stage: capture the latched level on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample <= '0;
        end else begin
            sample <= held;
        end
    end
endmodule

// File: rtl/gpio_port.sv
// Module: general-purpose I/O port top level.
// Holds the configuration registers, builds per-pin pad controls with a
// generate loop, synchronizes the pads and multiplexes register reads.
// Assumes a single clock domain and an active-low asynchronous reset.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              pullup_off,
    input  logic              sleep,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] drv_q;
    logic [WIDTH-1:0] pin_q;

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (bus_addr),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .drv_q   (drv_q)
    );

    for (genvar n = 0; n < WIDTH; n++) begin : g_pin
        gpio_pin_drive u_drive (
            .dir_bit    (dir_q[n]),
            .drv_bit    (drv_q[n]),
            .pu_disable (pullup_off),
            .oe         (pad_oe[n]),
            .out_val    (pad_out[n]),
            .pu_en      (pad_pu[n])
        );
    end

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .pad_in (pad_in),
        .sample (pin_q)
    );

    // Select the read data by address; zero when no read is requested.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                SEL_PIN: bus_rdata = pin_q;
                SEL_DIR: bus_rdata = dir_q;
                SEL_OUT: bus_rdata = drv_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Module: property checker for the I/O port, bound to every instance.
// Observes ports only.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              pullup_off,
    input logic              sleep,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_pu
);
    // R1: a direction write sets the enables on the next cycle.
    assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DIR) |=> (pad_oe == $past(bus_wdata)));

    // R2: an input pin never drives a high level.
    assert_input_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    // R3: pull-ups only on inputs, and never while globally disabled.
    assert_pullup_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_pu & pad_oe) == '0) && (!pullup_off || pad_pu == '0)));

    // R3: a drive write with zeros removes those pull-ups and drives.
    assert_drive_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_OUT) |=> (((pad_out | pad_pu) & ~$past(bus_wdata)) == '0));

    // R4: while reset is held the pads are released.
    assert_reset_release_R4: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0 && pad_pu == '0));

    // R5: no read strobe means idle read data.
    assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    // R7: a sustained sleep reads the sample as zero.
    assert_sleep_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep, 2) && $past(sleep) && sleep && bus_rd && bus_addr == SEL_PIN)
            |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gpio_port_test.sv
module gpio_port_test;
    import gpio_port_pkg::*;

    localparam int unsigned W = 8;

    logic          clk = 1'b0;
    logic          clk_run = 1'b1;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [W-1:0]  bus_rdata;
    logic          pullup_off = 1'b0;
    logic          sleep = 1'b0;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_oe;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_pu;

    int n_checks = 0;
    int n_fail = 0;
    logic [W-1:0] rd_val;

    gpio_port #(.WIDTH(W)) uut (.*);

    always #5 if (clk_run) clk = ~clk;

    // Vector: dir, drive, pull-up disable, expected oe, out, pu.
    localparam int NV = 8;
    localparam logic [47:0] VEC [NV] = '{
        {8'hCC, 8'hAA, 8'h00, 8'hCC, 8'h88, 8'h22},
        {8'hCC, 8'hAA, 8'h01, 8'hCC, 8'h88, 8'h00},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},
        {8'hFF, 8'h5A, 8'h00, 8'hFF, 8'h5A, 8'h00},
        {8'h0F, 8'h3C, 8'h00, 8'h0F, 8'h0C, 8'h30},
        {8'h0F, 8'h3C, 8'h01, 8'h0F, 8'h0C, 8'h00},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'h33, 8'h55, 8'h00, 8'h33, 8'h11, 8'h44}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4 oe in reset", pad_oe, 8'h00);
        check("R4 pu in reset", pad_pu, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(SEL_DIR, rd_val); check("R4 dir after reset", rd_val, 8'h00);
        bus_read(SEL_OUT, rd_val); check("R4 drive after reset", rd_val, 8'h00);
        // R5: idle read data
        #1 check("R5 idle rdata", bus_rdata, 8'h00);

        // R1 R2 R3 R9: vector table
        for (int i = 0; i < NV; i++) begin
            bus_write(SEL_DIR, VEC[i][47:40]);
            bus_write(SEL_OUT, VEC[i][39:32]);
            pullup_off = VEC[i][24];
            #1;
            check("R1 oe", pad_oe, VEC[i][23:16]);
            check("R2 out", pad_out, VEC[i][15:8]);
            check("R3 R9 pu", pad_pu, VEC[i][7:0]);
            bus_read(SEL_DIR, rd_val); check("R5 dir readback", rd_val, VEC[i][47:40]);
            bus_read(SEL_OUT, rd_val); check("R5 drive readback", rd_val, VEC[i][39:32]);
        end
        pullup_off = 1'b0;

        // R8: writes to sample and unused selects are ignored
        bus_write(SEL_DIR, 8'h96);
        bus_write(SEL_OUT, 8'h69);
        bus_write(SEL_PIN, 8'hFF);
        bus_write(SEL_NONE, 8'h00);
        bus_read(SEL_DIR, rd_val); check("R8 dir kept", rd_val, 8'h96);
        bus_read(SEL_OUT, rd_val); check("R8 drive kept", rd_val, 8'h69);
        bus_read(SEL_NONE, rd_val); check("R5 unused select", rd_val, 8'h00);

        // R6: synchronizer latency
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R6 settled low", rd_val, 8'h00);
        @(posedge clk);
        #1 pad_in = 8'hA5;
        @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R6 not yet visible", rd_val, 8'h00);
        @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R6 visible after edge", rd_val, 8'hA5);
        @(posedge clk);
        #1 pad_in = 8'h3C;
        @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R6 holds old", rd_val, 8'hA5);
        @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R6 second pattern", rd_val, 8'h3C);

        // R7: sleep forces the sample low
        pad_in = 8'hFF;
        repeat (2) @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R7 awake sample", rd_val, 8'hFF);
        sleep = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R7 asleep sample", rd_val, 8'h00);
        sleep = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(SEL_PIN, rd_val); check("R7 wake sample", rd_val, 8'hFF);

        // R4: asynchronous reset with the clock stopped
        bus_write(SEL_DIR, 8'hF0);
        bus_write(SEL_OUT, 8'hFF);
        #1 check("R4 pre-reset pu", pad_pu, 8'h0F);
        clk_run = 1'b0;
        #20 rst_n = 1'b0;
        #2;
        check("R4 async oe", pad_oe, 8'h00);
        check("R4 async pu", pad_pu, 8'h00);
        bus_read(SEL_OUT, rd_val); check("R4 async drive", rd_val, 8'h00);
        #5 rst_n = 1'b1;
        #3 clk_run = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 stays released", pad_oe, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule